// File: doc/BRIEF.md
# Dual-Channel DAC Holding and Trigger Controller

This block sits between a simple register port and a two-channel digital-to-analog converter. For each channel it keeps a 12-bit holding value, which software writes, and a separate 12-bit output code, which drives the converter. Software never writes the output code. A write can come in through several aliases. One alias takes a byte, one takes a right-justified 12-bit code and one takes a left-justified 12-bit code. Each alias exists for one channel alone and also as a packed dual word that loads both channels in one write. Whatever the alias, the value lands as one normalised 12-bit holding value.

Each channel moves its holding value to its output in one of two ways. With triggering off, the output simply follows the holding value. With triggering on, the move happens only on the trigger the channel has selected. That trigger is one of seven external inputs, which are synchronised and edge-detected, or a software trigger bit. After each triggered transfer the channel can raise a one-cycle request so that a DMA engine refills the holding value. Both channels can be made to update in the same cycle by giving them the same trigger source.

Top module: `dacc_top`

## Requirements
- R1: After reset, both output codes are 0, the control and software-trigger registers read 0, both enables are low and no DMA request is raised.
- R2: With a channel enabled and triggering off, its output code equals the holding value from the clock edge after the holding write.
- R3: Single-channel aliases live at byte address 0x20 + 0x10*ch. Offset +0 takes a byte from bits 7:0 and stores it as {byte, 4'b0}. Offset +4 takes bits 11:0. Offset +8 takes bits 15:4. All other write bits are ignored, and the other channel is left untouched.
- R4: Dual aliases load both holding values in one write. At 0x18, channel 0 takes {bits 7:0, 4'b0} and channel 1 takes {bits 15:8, 4'b0}. At 0x14, channel 0 takes bits 11:0 and channel 1 takes bits 27:16. At 0x10, channel 0 takes bits 15:4 and channel 1 takes bits 31:20.
- R5: With triggering on, the output code holds its value through holding writes and through events on unselected sources. It loads only on the selected source.
- R6: The trigger source values 0 to 6 select the external inputs ext_trig_i[0] to ext_trig_i[6]. A rise on the selected input loads the output at the third rising clock edge after the input rises. A level held high causes only one transfer.
- R7: When a triggered transfer happens with DMA requests enabled, the request is high for exactly the one cycle after the output loads. When DMA requests are disabled, no request is raised.
- R8: Software-trigger register 0x04: writing 1 to bit ch sets that channel's trigger bit, and the value 7 in the source field selects it. The transfer happens on the next edge and clears the bit. A bit set while that channel has another source selected stays set.
- R9: While a channel's enable is 0, its output code does not change and it raises no DMA request, whatever is written or triggered.
- R10: When both channels select the same external source, a dual write followed by one rising edge on that source updates both outputs in the same cycle.
- R11: The control register is at 0x00, with channel ch in byte ch. Its fields are: bit 0 enable, bit 1 trigger enable, bits 4:2 source, bit 5 DMA enable. Reads return control, the software-trigger bits, output codes at 0x08 and 0x0C, and the holding values at each channel's +4 alias. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| ext_trig_i | input | 7 | Asynchronous external trigger inputs |
| dac_en_o | output | 2 | Per-channel converter enable |
| dac_code_o | output | 24 | Output codes, channel ch in bits 12*ch+11:12*ch |
| dma_req_o | output | 2 | Per-channel DMA request pulse |

## Verification
The bench sweeps every alias for both channels and puts junk in the bits outside each field. A decoder with a wrong bit slice or a missing zero fill for byte data returns a wrong code, and one that writes the wrong channel shows up in the other channel's code. The trigger tests count cycles from the rise of an external input. They catch a missing synchroniser stage or an extra one, an edge detector that fires again on a held level, a transfer taken from an unselected source, and a DMA pulse that is late, too long or not gated by its enable. Further cases check that a software trigger bit clears itself only when its own transfer happens, that a disabled channel stays frozen, and that two channels on one source update in the same cycle.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int NUM_CH      = 2;
  localparam int CODE_W      = 12;
  localparam int TSEL_W      = 3;
  localparam int NUM_EXT     = (1 << TSEL_W) - 1;
  localparam int SW_SEL      = NUM_EXT;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 32;
  localparam int LANE_W      = 16;
  localparam int BYTE_W      = 8;
  localparam int CTRL_STRIDE = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] A_SWTRIG   = 6'h04;
  localparam logic [ADDR_W-1:0] A_DUAL_L12 = 6'h10;
  localparam logic [ADDR_W-1:0] A_DUAL_R12 = 6'h14;
  localparam logic [ADDR_W-1:0] A_DUAL_R8  = 6'h18;
  localparam int A_OUT_BASE  = 'h08;
  localparam int A_CH_BASE   = 'h20;
  localparam int A_CH_STRIDE = 'h10;
  localparam logic [ADDR_W-1:0] OFF_R8  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_R12 = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_L12 = 6'h08;

  typedef enum logic [1:0] {FMT_R8, FMT_R12, FMT_L12} fmt_e;

  typedef struct packed {
    logic              dma_en;
    logic [TSEL_W-1:0] tsel;
    logic              trig_en;
    logic              en;
  } ch_ctrl_t;

  localparam int CTRL_W = $bits(ch_ctrl_t);

  // lane 0 for single aliases, channel index for dual aliases
  function automatic logic [CODE_W-1:0] extract(fmt_e f, logic [DATA_W-1:0] w, int lane);
    case (f)
      FMT_R8:  return {w[lane*BYTE_W +: BYTE_W], {(CODE_W-BYTE_W){1'b0}}};
      FMT_R12: return w[lane*LANE_W +: CODE_W];
      default: return w[lane*LANE_W + (LANE_W-CODE_W) +: CODE_W];
    endcase
  endfunction
endpackage

// File: rtl/dacc_wr_decode.sv
module dacc_wr_decode
  import dacc_pkg::*;
(
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [NUM_CH-1:0]        hold_we_o,
  output logic [NUM_CH*CODE_W-1:0] hold_d_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(A_CH_BASE + c*A_CH_STRIDE);
    logic sel;
    fmt_e fmt;
    int   lane;

    always_comb begin
      sel  = 1'b1;
      fmt  = FMT_R12;
      lane = c;
      if (addr_i == A_DUAL_R8)       fmt = FMT_R8;
      else if (addr_i == A_DUAL_R12) fmt = FMT_R12;
      else if (addr_i == A_DUAL_L12) fmt = FMT_L12;
      else begin
        lane = 0;
        if (addr_i == BASE + OFF_R8)       fmt = FMT_R8;
        else if (addr_i == BASE + OFF_R12) fmt = FMT_R12;
        else if (addr_i == BASE + OFF_L12) fmt = FMT_L12;
        else                               sel = 1'b0;
      end
    end

    assign hold_we_o[c]                  = we_i & sel;
    assign hold_d_o[c*CODE_W +: CODE_W]  = extract(fmt, wdata_i, lane);
  end
endmodule

// File: rtl/dacc_trig_sync.sv
module dacc_trig_sync #(
  parameter int N      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] edge_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], trig_i[b]};
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign edge_o[b] = sh_q[STAGES-1] & ~prev_q;

    p_edge_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o[b] |=> !edge_o[b])
      else $error("R6: edge detect held for two cycles on input %0d", b);
  end
endmodule

// File: rtl/dacc_channel.sv
module dacc_channel
  import dacc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_ctrl_t          ctrl_i,
  input  logic              evt_i,
  input  logic              hold_we_i,
  input  logic [CODE_W-1:0] hold_d_i,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] code_o,
  output logic              xfer_o,
  output logic              dma_req_o
);
  logic [CODE_W-1:0] hold_q, out_q;
  logic              dma_q, track;

  assign xfer_o = ctrl_i.en & ctrl_i.trig_en & evt_i;
  // untriggered: output follows holding one edge later
  assign track  = ctrl_i.en & ~ctrl_i.trig_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
      dma_q  <= 1'b0;
    end else begin
      if (hold_we_i)        hold_q <= hold_d_i;
      if (xfer_o || track)  out_q  <= hold_q;
      dma_q <= xfer_o & ctrl_i.dma_en;
    end
  end

  assign hold_o    = hold_q;
  assign code_o    = out_q;
  assign dma_req_o = dma_q;

  p_out_frozen_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |=> $stable(out_q))
    else $error("R9: output changed on a disabled channel");

  p_dma_after_xfer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(xfer_o))
    else $error("R7: DMA request without a preceding transfer");

  p_dma_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !ctrl_i.dma_en) |=> !dma_req_o)
    else $error("R7: DMA request raised while DMA disabled");
endmodule

// File: rtl/dacc_top.sv
module dacc_top
  import dacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  input  logic [NUM_EXT-1:0]       ext_trig_i,
  output logic [NUM_CH-1:0]        dac_en_o,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o,
  output logic [NUM_CH-1:0]        dma_req_o
);
  ch_ctrl_t                  ctrl_q [NUM_CH];
  logic [NUM_CH-1:0]         swtrig_q, evt, xfer, hold_we;
  logic [NUM_CH*CODE_W-1:0]  hold_d;
  logic [CODE_W-1:0]         hold_val [NUM_CH];
  logic [CODE_W-1:0]         code_val [NUM_CH];
  logic [NUM_EXT-1:0]        ext_edge;
  logic                      ctrl_wr, sw_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_i == A_CTRL);
  assign sw_wr   = reg_we_i && (reg_addr_i == A_SWTRIG);

  dacc_wr_decode u_dec (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hold_we_o (hold_we),
    .hold_d_o  (hold_d)
  );

  dacc_trig_sync #(.N(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (ext_trig_i),
    .edge_o (ext_edge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++) ctrl_q[c] <= '0;
      swtrig_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ctrl_wr) ctrl_q[c] <= reg_wdata_i[c*CTRL_STRIDE +: CTRL_W];
        // a new set wins over the clear of the same cycle
        if (sw_wr && reg_wdata_i[c])
          swtrig_q[c] <= 1'b1;
        else if (xfer[c] && ctrl_q[c].tsel == TSEL_W'(SW_SEL))
          swtrig_q[c] <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_EXT:0] src;
    assign src    = {swtrig_q[c], ext_edge};
    assign evt[c] = src[ctrl_q[c].tsel];

    dacc_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_i    (ctrl_q[c]),
      .evt_i     (evt[c]),
      .hold_we_i (hold_we[c]),
      .hold_d_i  (hold_d[c*CODE_W +: CODE_W]),
      .hold_o    (hold_val[c]),
      .code_o    (code_val[c]),
      .xfer_o    (xfer[c]),
      .dma_req_o (dma_req_o[c])
    );

    assign dac_code_o[c*CODE_W +: CODE_W] = code_val[c];
    assign dac_en_o[c] = ctrl_q[c].en;

    p_swtrig_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer[c] && ctrl_q[c].tsel == TSEL_W'(SW_SEL) && !(sw_wr && reg_wdata_i[c]))
      |=> !swtrig_q[c])
      else $error("R8: software trigger bit not cleared on channel %0d", c);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL) begin
      for (int c = 0; c < NUM_CH; c++) reg_rdata_o[c*CTRL_STRIDE +: CTRL_W] = ctrl_q[c];
    end else if (reg_addr_i == A_SWTRIG) begin
      reg_rdata_o[NUM_CH-1:0] = swtrig_q;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr_i == ADDR_W'(A_OUT_BASE + c*4))
        reg_rdata_o[CODE_W-1:0] = code_val[c];
      if (reg_addr_i == ADDR_W'(A_CH_BASE + c*A_CH_STRIDE) + OFF_R12)
        reg_rdata_o[CODE_W-1:0] = hold_val[c];
    end
  end
endmodule

// File: tb/tb_dacc_top.sv
module tb_dacc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  ext = '0;
  logic [1:0]  en_o, dma;
  logic [23:0] codes;
  int n_chk = 0, n_fail = 0;
  logic [11:0] last [2];
  logic [31:0] rv;

  always #10 clk = ~clk;

  dacc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_trig_i(ext),
    .dac_en_o(en_o), .dac_code_o(codes), .dma_req_o(dma)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic [11:0] code(int ch);
    return codes[ch*12 +: 12];
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 code0", code(0), 0);
    check("R1 code1", code(1), 0);
    check("R1 dma", dma, 0);
    check("R1 en", en_o, 0);
    rd(6'h00, rv); check("R1 ctrl", rv, 0);
    rd(6'h04, rv); check("R1 swtrig", rv, 0);

    // both enabled, triggering off
    wr(6'h00, 32'h0000_0101);
    last[0] = 0; last[1] = 0;

    // R3 single-alias sweep with junk outside each field
    for (int ch = 0; ch < 2; ch++)
      for (int f = 0; f < 3; f++)
        for (int i = 0; i < 32; i++) begin
          logic [11:0] v, e;
          logic [31:0] w;
          v = 12'((i*131 + ch*977 + f*53) & 12'hFFF);
          case (f)
            0: begin w = {24'hA5C3E1, v[7:0]}; e = {v[7:0], 4'h0}; end
            1: begin w = {20'h5A3C1, v};       e = v; end
            default: begin w = {16'hC3A5, v, 4'hB}; e = v; end
          endcase
          wr(6'(32 + ch*16 + f*4), w);
          @(negedge clk);
          last[ch] = e;
          check("R3 code", code(ch), e);
          check("R3 other channel untouched", code(1-ch), last[1-ch]);
        end
    rd(6'h24, rv); check("R11 hold0 readback", rv, last[0]);
    rd(6'h34, rv); check("R11 hold1 readback", rv, last[1]);
    rd(6'h08, rv); check("R11 out0 readback", rv, last[0]);
    rd(6'h0C, rv); check("R11 out1 readback", rv, last[1]);
    rd(6'h3C, rv); check("R11 unmapped reads 0", rv, 0);

    // R4 dual-alias sweep
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 16; i++) begin
        logic [11:0] a, b, ea, eb;
        logic [31:0] w;
        logic [5:0]  ad;
        a = 12'((i*389 + f*17) & 12'hFFF);
        b = 12'((i*611 + 5 + f*29) & 12'hFFF);
        case (f)
          0: begin w = {16'h9E37, b[7:0], a[7:0]}; ea = {a[7:0], 4'h0}; eb = {b[7:0], 4'h0}; ad = 6'h18; end
          1: begin w = {4'hD, b, 4'h6, a}; ea = a; eb = b; ad = 6'h14; end
          default: begin w = {b, 4'h7, a, 4'h9}; ea = a; eb = b; ad = 6'h10; end
        endcase
        wr(ad, w);
        @(negedge clk);
        check("R4 dual ch0", code(0), ea);
        check("R4 dual ch1", code(1), eb);
        last[0] = ea; last[1] = eb;
      end

    // R2 one-edge lag in untriggered mode
    wr(6'h24, 32'h0000_0ACE);
    check("R2 not before next edge", code(0), last[0]);
    @(negedge clk);
    check("R2 follows holding", code(0), 12'hACE);
    last[0] = 12'hACE;

    // ch0: en,trig,src 7,dma = 0x3F ; ch1: en,trig,src 3 = 0x0F
    wr(6'h00, 32'h0000_0F3F);
    rd(6'h00, rv); check("R11 ctrl readback", rv, 32'h0000_0F3F);
    wr(6'h24, 32'h0000_0123);
    repeat (3) @(negedge clk);
    check("R5 held without trigger", code(0), last[0]);
    check("R7 no dma without trigger", dma, 0);
    wr(6'h04, 32'h1);
    check("R8 not before next edge", code(0), last[0]);
    check("R8 no dma yet", dma, 0);
    @(negedge clk);
    check("R8 software transfer", code(0), 12'h123);
    check("R7 dma pulse ch0", dma, 2'b01);
    last[0] = 12'h123;
    @(negedge clk);
    check("R7 dma one cycle", dma, 0);
    rd(6'h04, rv); check("R8 bit self-clears", rv, 0);

    // software bit on a channel that selects an external source
    wr(6'h34, 32'h0000_0456);
    wr(6'h04, 32'h2);
    repeat (3) @(negedge clk);
    check("R5 ch1 ignores unselected soft trigger", code(1), last[1]);
    rd(6'h04, rv); check("R8 unselected bit stays set", rv, 2);

    // wrong external source
    @(negedge clk); ext[2] = 1'b1;
    repeat (4) @(negedge clk); ext[2] = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 ch1 ignores source 2", code(1), last[1]);

    // selected external source, latency count
    ext[3] = 1'b1;
    @(negedge clk); check("R6 edge1 old", code(1), last[1]);
    @(negedge clk); check("R6 edge2 old", code(1), last[1]);
    @(negedge clk); check("R6 edge3 new", code(1), 12'h456);
    check("R7 no dma when disabled", dma, 0);
    last[1] = 12'h456;
    wr(6'h34, 32'h0000_0789);
    repeat (5) @(negedge clk);
    check("R6 held level gives one transfer", code(1), last[1]);
    ext[3] = 1'b0;
    repeat (3) @(negedge clk);

    // R10 both channels on source 5 with dma: byte 0x37
    wr(6'h00, 32'h0000_3737);
    wr(6'h14, 32'h0321_0ABC);
    repeat (2) @(negedge clk);
    ext[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 ch0 old", code(0), last[0]);
    check("R10 ch1 old", code(1), last[1]);
    @(negedge clk);
    check("R10 ch0 new", code(0), 12'hABC);
    check("R10 ch1 new", code(1), 12'h321);
    check("R7 both dma", dma, 2'b11);
    @(negedge clk);
    check("R7 both dma drop", dma, 0);
    ext[5] = 1'b0;
    last[0] = 12'hABC; last[1] = 12'h321;
    repeat (3) @(negedge clk);

    // R9 channel 0 disabled
    wr(6'h00, 32'h0000_3700);
    check("R9 enable outputs", en_o, 2'b10);
    wr(6'h14, 32'h0777_0555);
    ext[5] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 ch0 frozen", code(0), last[0]);
    check("R9 ch0 no dma", dma, 2'b10);
    check("R9 ch1 still runs", code(1), 12'h777);
    ext[5] = 1'b0;
    wr(6'h24, 32'h0000_0FFF);
    repeat (2) @(negedge clk);
    check("R9 ch0 frozen to direct write", code(0), last[0]);

    finish_run();
  end
endmodule